// File: doc/BRIEF.md
# Framed Stream Protocol Monitor

This block watches an 8-bit response stream built on a valid/accept handshake, where each beat may carry a start flag or a stop flag. It also watches the request stream of the same register-access link. It drives nothing on either stream. When a handshake or framing rule is broken, it sets a violation flag and raises a pulse.

Two kinds of rule are checked. The beat-level rules check the handshake itself: the flags must be legal, and a stalled beat must hold still until it is accepted. The frame-level rules come from the most recent request seen. A read request must be answered by a header beat, one plain data beat and a footer beat. A write request must be answered by a header beat and then a footer beat. Every accepted footer byte must also carry an allowed status code.

Each rule owns one sticky flag bit. The flag stays set until reset. A shared pulse marks every cycle that follows a new rule hit.

Top module: `frame_proto_mon`

## Requirements
- R1: A response cycle with start and stop both high sets flag bit 0 on the next clock edge.
- R2: A response cycle with start or stop high while valid is low sets flag bit 1.
- R3: If valid was high and accept low in one cycle, and valid is low in the following cycle, flag bit 2 is set.
- R4: If valid was high and accept low in one cycle, and valid is still high in the following cycle, then any change of data, start or stop between the two cycles sets flag bit 3.
- R5: A read request is an accepted request beat with start high, stop high and command 0 in data bits [3:0]. After it, the accepted response beats must be, in order:
  - a header beat (start high, stop low);
  - a data beat (both flags low);
  - a footer beat (stop high, start low).
  Any other accepted beat sets flag bit 4.
- R6: A write request is an accepted request beat with start high, stop low and command 1 in data bits [3:0]. After it, the accepted response beats must be a header beat and then a footer beat. Any other accepted beat sets flag bit 4.
- R7: The following do not arm a frame: a request beat that is not accepted, or a request with any other command/stop combination. An accepted response beat while no frame is armed sets flag bit 4, and the tracker stays unarmed.
- R8: An accepted response beat with stop high and a data byte greater than 0x01 sets flag bit 5. Footer bytes 0x00 and 0x01 are legal.
- R9: Flag bits stay set until reset. The pulse output is high for exactly one cycle after each cycle in which any rule fired, and low otherwise.
- R10: While reset is low at a clock edge, the flags, the pulse, the handshake history and the frame tracker are all cleared. An armed frame does not survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request stream valid |
| req_accept | input | 1 | Request stream accept |
| req_start | input | 1 | Request start flag |
| req_stop | input | 1 | Request stop flag |
| req_data | input | 8 | Request byte; bits [3:0] hold the command |
| rsp_valid | input | 1 | Response stream valid |
| rsp_accept | input | 1 | Response stream accept |
| rsp_start | input | 1 | Response start flag |
| rsp_stop | input | 1 | Response stop flag |
| rsp_data | input | 8 | Response byte |
| viol_flags | output | 6 | Sticky flags: bit 0 both flags, 1 flag without valid, 2 valid dropped, 3 stalled beat changed, 4 frame order, 5 footer code |
| viol_pulse | output | 1 | One-cycle pulse after any rule fires |

## Verification
The bench sweeps all sixteen commands, with the request stop flag both low and high, and always answers with a header/footer pair. Only the single write encoding may pass. A monitor that decodes the command field or the stop flag wrongly, or that arms on an unaccepted request, flags the wrong cases.

All 256 footer codes are swept against the 0x01 limit, so an off-by-one compare shows up at 0x01 or 0x02. A read answered without its data beat, and a write answered with an extra one, catch a tracker that ignores the request type.

Stall cases cover a dropped valid and a changed byte separately, so a monitor that only compares on accepted beats misses them. Reset is applied while a frame is armed, which exposes a tracker that keeps its state through reset.

// File: rtl/frame_mon_pkg.sv
// Shared definitions for the framed stream monitor.
// Assumes: flag bit positions are part of the block's output contract.
package frame_mon_pkg;
    localparam int RULE_N     = 6;
    localparam int RB_BOTH    = 0;
    localparam int RB_NOVALID = 1;
    localparam int RB_DROP    = 2;
    localparam int RB_HOLD    = 3;
    localparam int RB_ORDER   = 4;
    localparam int RB_FOOTER  = 5;

    typedef enum logic [1:0] {
        TRK_IDLE = 2'd0,
        TRK_HDR  = 2'd1,
        TRK_DATA = 2'd2,
        TRK_FTR  = 2'd3
    } trk_state_t;
endpackage

// File: rtl/frame_beat_rules.sv
// Beat-level handshake rules on the response stream.
// Does: detects illegal flag combinations and changes to a stalled beat.
// Assumes: rst_n is synchronous and active low; history is cleared by reset.
module frame_beat_rules #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              accept,
    input  logic              start,
    input  logic              stop,
    input  logic [DATA_W-1:0] data,
    output logic              ev_both,
    output logic              ev_novalid,
    output logic              ev_drop,
    output logic              ev_hold
);
    logic              prev_valid;
    logic              prev_accept;
    logic              prev_start;
    logic              prev_stop;
    logic [DATA_W-1:0] prev_data;
    logic              stalled_prev;

    // Capture the previous cycle's beat so hold rules can compare against it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_valid  <= 1'b0;
            prev_accept <= 1'b0;
            prev_start  <= 1'b0;
            prev_stop   <= 1'b0;
            prev_data   <= '0;
        end else begin
            prev_valid  <= valid;
            prev_accept <= accept;
            prev_start  <= start;
            prev_stop   <= stop;
            prev_data   <= data;
        end
    end

    // Evaluate the four beat-level rules for the current cycle.
    always_comb begin
        stalled_prev = prev_valid && !prev_accept;
        ev_both      = start && stop;
        ev_novalid   = (start || stop) && !valid;
        ev_drop      = stalled_prev && !valid;
        ev_hold      = stalled_prev && valid &&
                       ((start != prev_start) || (stop != prev_stop) ||
                        (data != prev_data));
    end
endmodule

// File: rtl/frame_order_tracker.sv
// Frame-level ordering and footer code rules.
// Does: arms an expected response shape from the latest request and checks
// each accepted response beat against it; checks every footer byte.
// Assumes: a request accepted in the same cycle as a response beat re-arms
// after that beat has been judged against the old expectation.
module frame_order_tracker
    import frame_mon_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int CMD_W      = 4,
    parameter int READ_CMD   = 0,
    parameter int WRITE_CMD  = 1,
    parameter int FOOTER_MAX = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_accept,
    input  logic              req_start,
    input  logic              req_stop,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic              rsp_valid,
    input  logic              rsp_accept,
    input  logic              rsp_start,
    input  logic              rsp_stop,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              ev_order,
    output logic              ev_footer
);
    localparam logic [CMD_W-1:0]  CMD_RD  = CMD_W'(READ_CMD);
    localparam logic [CMD_W-1:0]  CMD_WR  = CMD_W'(WRITE_CMD);
    localparam logic [DATA_W-1:0] FTR_LIM = DATA_W'(FOOTER_MAX);

    trk_state_t state_q, state_d;
    logic       read_q, read_d;
    logic       req_fire, arm_read, arm_write, rsp_fire;
    logic       is_hdr, is_mid, is_ftr;

    // Decode request arming and the kind of the current response beat.
    always_comb begin
        req_fire  = req_valid && req_accept && req_start;
        arm_read  = req_fire && req_stop && (req_cmd == CMD_RD);
        arm_write = req_fire && !req_stop && (req_cmd == CMD_WR);
        rsp_fire  = rsp_valid && rsp_accept;
        is_hdr    = rsp_start && !rsp_stop;
        is_mid    = !rsp_start && !rsp_stop;
        is_ftr    = rsp_stop && !rsp_start;
    end

    // Next expectation and order verdict for an accepted response beat.
    always_comb begin
        state_d  = state_q;
        read_d   = read_q;
        ev_order = 1'b0;
        if (rsp_fire) begin
            unique case (state_q)
                TRK_IDLE: ev_order = 1'b1;
                TRK_HDR: begin
                    if (is_hdr) state_d = read_q ? TRK_DATA : TRK_FTR;
                    else begin
                        ev_order = 1'b1;
                        state_d  = TRK_IDLE;
                    end
                end
                TRK_DATA: begin
                    if (is_mid) state_d = TRK_FTR;
                    else begin
                        ev_order = 1'b1;
                        state_d  = TRK_IDLE;
                    end
                end
                TRK_FTR: begin
                    ev_order = !is_ftr;
                    state_d  = TRK_IDLE;
                end
                default: state_d = TRK_IDLE;
            endcase
        end
        if (arm_read || arm_write) begin
            state_d = TRK_HDR;
            read_d  = arm_read;
        end
    end

    // Footer code rule applies to every accepted stop beat.
    always_comb begin
        ev_footer = rsp_fire && rsp_stop && (rsp_data > FTR_LIM);
    end

    // Hold the armed expectation between cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TRK_IDLE;
            read_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            read_q  <= read_d;
        end
    end

    AST_READ_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        arm_read |=> (state_q == TRK_HDR && read_q)); // R5
    AST_WRITE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        arm_write |=> (state_q == TRK_HDR && !read_q)); // R6
    AST_FOOTER_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRK_FTR && rsp_fire && !req_fire) |=> state_q == TRK_IDLE); // R5
    AST_IDLE_BEAT_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRK_IDLE && rsp_fire) |-> ev_order); // R7
endmodule

// File: rtl/frame_viol_collect.sv
// Sticky violation flags and a one-cycle summary pulse.
// Does: ORs each rule event into its own flag and pulses after any hit.
// Assumes: event vector bit positions follow frame_mon_pkg indices.
module frame_viol_collect #(
    parameter int RULES = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RULES-1:0] ev,
    output logic [RULES-1:0] flags,
    output logic             pulse
);
    logic [RULES-1:0] flags_q;
    logic             pulse_q;

    // One sticky bit per rule.
    for (genvar g = 0; g < RULES; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) flags_q[g] <= 1'b0;
            else if (ev[g]) flags_q[g] <= 1'b1;
        end
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            flags_q[g] |=> flags_q[g]); // R9
    end

    // Pulse follows any rule hit by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else pulse_q <= |ev;
    end

    assign flags = flags_q;
    assign pulse = pulse_q;

    AST_PULSE_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> (flags_q != '0)); // R9
endmodule

// File: rtl/frame_proto_mon.sv
// Passive monitor for a framed valid/accept response stream.
// Does: combines beat-level handshake rules and frame-level ordering rules
// into sticky per-rule flags and a violation pulse. Drives no stream signal.
// Assumes: synchronous active-low reset; command in the low request bits.
module frame_proto_mon
    import frame_mon_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int CMD_W      = 4,
    parameter int READ_CMD   = 0,
    parameter int WRITE_CMD  = 1,
    parameter int FOOTER_MAX = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_accept,
    input  logic              req_start,
    input  logic              req_stop,
    input  logic [DATA_W-1:0] req_data,
    input  logic              rsp_valid,
    input  logic              rsp_accept,
    input  logic              rsp_start,
    input  logic              rsp_stop,
    input  logic [DATA_W-1:0] rsp_data,
    output logic [RULE_N-1:0] viol_flags,
    output logic              viol_pulse
);
    logic [RULE_N-1:0] ev;
    logic              unused_req_hi;

    assign unused_req_hi = ^req_data[DATA_W-1:CMD_W];

    frame_beat_rules #(.DATA_W(DATA_W)) u_beat (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid      (rsp_valid),
        .accept     (rsp_accept),
        .start      (rsp_start),
        .stop       (rsp_stop),
        .data       (rsp_data),
        .ev_both    (ev[RB_BOTH]),
        .ev_novalid (ev[RB_NOVALID]),
        .ev_drop    (ev[RB_DROP]),
        .ev_hold    (ev[RB_HOLD])
    );

    frame_order_tracker #(
        .DATA_W     (DATA_W),
        .CMD_W      (CMD_W),
        .READ_CMD   (READ_CMD),
        .WRITE_CMD  (WRITE_CMD),
        .FOOTER_MAX (FOOTER_MAX)
    ) u_order (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_accept (req_accept),
        .req_start  (req_start),
        .req_stop   (req_stop),
        .req_cmd    (req_data[CMD_W-1:0]),
        .rsp_valid  (rsp_valid),
        .rsp_accept (rsp_accept),
        .rsp_start  (rsp_start),
        .rsp_stop   (rsp_stop),
        .rsp_data   (rsp_data),
        .ev_order   (ev[RB_ORDER]),
        .ev_footer  (ev[RB_FOOTER])
    );

    frame_viol_collect #(.RULES(RULE_N)) u_collect (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (ev),
        .flags (viol_flags),
        .pulse (viol_pulse)
    );

    AST_BOTH_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_start && rsp_stop) |=> viol_flags[RB_BOTH]); // R1
    AST_NOVALID_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        ((rsp_start || rsp_stop) && !rsp_valid) |=> viol_flags[RB_NOVALID]); // R2
    AST_DROP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (!rsp_valid && $past(rsp_valid && !rsp_accept && rst_n)) |=> viol_flags[RB_DROP]); // R3
    AST_HOLD_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(rsp_valid && !rsp_accept && rst_n) &&
         rsp_data != $past(rsp_data)) |=> viol_flags[RB_HOLD]); // R4
    AST_FOOTER_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_accept && rsp_stop && rsp_data > DATA_W'(FOOTER_MAX))
        |=> viol_flags[RB_FOOTER]); // R8
endmodule

// File: tb/frame_proto_mon_test.sv
`timescale 1ns/1ps
module frame_proto_mon_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 0, req_accept = 0, req_start = 0, req_stop = 0;
    logic [7:0] req_data = 0;
    logic       rsp_valid = 0, rsp_accept = 0, rsp_start = 0, rsp_stop = 0;
    logic [7:0] rsp_data = 0;
    logic [5:0] viol_flags;
    logic       viol_pulse;
    int         checks = 0;
    int         errors = 0;
    bit         done = 0;

    always #10 clk = ~clk;

    frame_proto_mon uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_accept(req_accept), .req_start(req_start),
        .req_stop(req_stop), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_accept(rsp_accept), .rsp_start(rsp_start),
        .rsp_stop(rsp_stop), .rsp_data(rsp_data),
        .viol_flags(viol_flags), .viol_pulse(viol_pulse)
    );

    task automatic idle();
        @(negedge clk);
        req_valid = 0; req_accept = 0; req_start = 0; req_stop = 0; req_data = 0;
        rsp_valid = 0; rsp_accept = 0; rsp_start = 0; rsp_stop = 0; rsp_data = 0;
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic rsp_beat(input logic v, input logic a, input logic s,
                            input logic p, input logic [7:0] d);
        @(negedge clk);
        req_valid = 0; req_accept = 0; req_start = 0; req_stop = 0;
        rsp_valid = v; rsp_accept = a; rsp_start = s; rsp_stop = p; rsp_data = d;
    endtask

    task automatic req_beat(input logic acc, input logic [3:0] cmd, input logic p);
        @(negedge clk);
        rsp_valid = 0; rsp_accept = 0; rsp_start = 0; rsp_stop = 0; rsp_data = 0;
        req_valid = 1; req_accept = acc; req_start = 1; req_stop = p;
        req_data = {4'h5, cmd};
    endtask

    task automatic chk_flags(input string tag, input logic [5:0] exp);
        checks++;
        if (viol_flags !== exp) begin
            errors++;
            $display("FAIL %s flags actual=%b expected=%b", tag, viol_flags, exp);
        end
    endtask

    task automatic chk_pulse(input string tag, input logic exp);
        checks++;
        if (viol_pulse !== exp) begin
            errors++;
            $display("FAIL %s pulse actual=%b expected=%b", tag, viol_pulse, exp);
        end
    endtask

    initial begin
        #3000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        do_reset();
        idle();
        chk_flags("R10 reset", 6'h00);
        chk_pulse("R10 reset", 1'b0);

        // R5: legal read frame
        req_beat(1, 4'h0, 1); rsp_beat(1, 1, 1, 0, 8'hA0);
        rsp_beat(1, 1, 0, 0, 8'h3C); rsp_beat(1, 1, 0, 1, 8'h00); idle();
        chk_flags("R5 legal read", 6'h00);

        // R6: legal write frame, with a stalled header first
        req_beat(1, 4'h1, 0); rsp_beat(1, 0, 1, 0, 8'hA1); rsp_beat(1, 1, 1, 0, 8'hA1);
        rsp_beat(1, 1, 0, 1, 8'h01); idle();
        chk_flags("R6 legal write", 6'h00);

        // R5: read answered without data beat
        do_reset();
        req_beat(1, 4'h0, 1); rsp_beat(1, 1, 1, 0, 8'hA0); rsp_beat(1, 1, 0, 1, 8'h00); idle();
        chk_flags("R5 missing data", 6'h10);

        // R6: write answered with an extra data beat
        do_reset();
        req_beat(1, 4'h1, 0); rsp_beat(1, 1, 1, 0, 8'hA1); rsp_beat(1, 1, 0, 0, 8'h11);
        rsp_beat(1, 1, 0, 1, 8'h00); idle();
        chk_flags("R6 extra data", 6'h10);

        // R7: response with nothing armed; unaccepted request does not arm
        do_reset();
        rsp_beat(1, 1, 1, 0, 8'h00); idle();
        chk_flags("R7 unarmed beat", 6'h10);
        do_reset();
        req_beat(0, 4'h1, 0); rsp_beat(1, 1, 1, 0, 8'h00); rsp_beat(1, 1, 0, 1, 8'h00); idle();
        chk_flags("R7 unaccepted request", 6'h10);

        // R6/R7: command and stop sweep, answered with header+footer
        for (int c = 0; c < 16; c++) begin
            for (int p = 0; p < 2; p++) begin
                do_reset();
                req_beat(1, c[3:0], p[0]);
                rsp_beat(1, 1, 1, 0, 8'h80); rsp_beat(1, 1, 0, 1, 8'h00); idle();
                chk_flags((c == 1 && p == 0) ? "R6 sweep" : "R7 sweep",
                          (c == 1 && p == 0) ? 6'h00 : 6'h10);
            end
        end

        // R8: footer code sweep
        for (int v = 0; v < 256; v++) begin
            do_reset();
            req_beat(1, 4'h1, 0); rsp_beat(1, 1, 1, 0, 8'h80);
            rsp_beat(1, 1, 0, 1, v[7:0]); idle();
            chk_flags("R8 footer", (v > 1) ? 6'h20 : 6'h00);
        end

        // R1: start and stop together on an accepted beat (also unarmed)
        do_reset();
        rsp_beat(1, 1, 1, 1, 8'h00); idle();
        chk_flags("R1 both flags", 6'h11);

        // R2 + R9: flag without valid, pulse timing and stickiness
        do_reset();
        rsp_beat(0, 0, 1, 0, 8'h00); idle();
        chk_flags("R2 no valid", 6'h02);
        chk_pulse("R9 pulse high", 1'b1);
        idle();
        chk_pulse("R9 pulse low", 1'b0);
        repeat (20) idle();
        chk_flags("R9 sticky", 6'h02);
        rsp_beat(0, 0, 0, 1, 8'h00); idle();
        chk_pulse("R9 pulse repeat hit", 1'b1);

        // R3: valid dropped while stalled
        do_reset();
        rsp_beat(1, 0, 1, 0, 8'h05); rsp_beat(0, 0, 0, 0, 8'h00); idle();
        chk_flags("R3 valid drop", 6'h04);

        // R4: stalled byte changes before accept
        do_reset();
        req_beat(1, 4'h1, 0); rsp_beat(1, 0, 1, 0, 8'h05); rsp_beat(1, 0, 1, 0, 8'h06);
        rsp_beat(1, 1, 1, 0, 8'h06); rsp_beat(1, 1, 0, 1, 8'h00); idle();
        chk_flags("R4 hold change", 6'h08);

        // R10: armed frame and flags do not survive reset
        do_reset();
        rsp_beat(0, 0, 1, 0, 8'h00); req_beat(1, 4'h1, 0);
        do_reset();
        idle();
        chk_flags("R10 flags cleared", 6'h00);
        rsp_beat(1, 1, 1, 0, 8'h80); rsp_beat(1, 1, 0, 1, 8'h00); idle();
        chk_flags("R10 tracker cleared", 6'h10);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule